// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge gives a fast host a narrow, indirect path into registers that live in a slow, always-on domain. The host sees a small memory-mapped window of four word registers. It fills in a target address, a byte-enable word and a data word, then sets a start bit. The bridge performs exactly one access on the target-side register port and shows itself busy until that access completes.

The byte-enable word does two jobs. Its upper nibble is a write qualifier: a nonzero value makes the transfer a write, and zero makes it a read. Its lower nibble gives per-byte write strobes. When a read finishes, the data register holds the word returned by the target. The target port uses a request/acknowledge handshake, so any response latency is tolerated. Software polls the control word before and after each access. While a transfer is in flight, the bridge refuses anything that could disturb it.

Top module: `regwin_bridge`

## Requirements
- R1: After reset the bridge is idle, t_req is low, and all four window words read as zero.
- R2: The window decodes h_addr[3:2]: 0 is control, 1 is byte-enable (8 bits, zero-extended on read), 2 is target address (TAW bits, zero-extended), 3 is data. Address, byte-enable and data read back what was written while idle, and loading them never raises t_req.
- R3: A host write to control with bit 0 set, while idle, starts one transfer. Control then reads 1 until the transfer ends and 0 otherwise. When the target acknowledges L cycles after t_req rises, control reads 1 for exactly L+1 cycles.
- R4: When byte-enable bits 7:4 are zero, the transfer is a read: t_we is 0 and t_strb is 0. The data register takes t_rdata on the acknowledge cycle.
- R5: When byte-enable bits 7:4 are nonzero, the transfer is a write: t_we is 1, t_strb equals byte-enable bits 3:0 (bit i enables byte i), and t_wdata equals the data register. Only the strobed bytes change at the target.
- R6: While t_req is high and t_ack is low, t_req, t_addr, t_we, t_strb and t_wdata stay unchanged. t_req falls in the cycle after t_ack.
- R7: While busy, a further start is ignored, and host writes to the address, byte-enable and data registers are dropped. The in-flight transfer and the window contents are unaffected.
- R8: A write to control with bit 0 clear does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe |
| h_wr | input | 1 | Host write (with h_sel) |
| h_addr | input | 4 | Host byte offset into the window |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Window word selected by h_addr |
| t_req | output | 1 | Target access request |
| t_we | output | 1 | Target access is a write |
| t_addr | output | TAW | Target register address |
| t_strb | output | DW/8 | Target byte write strobes |
| t_wdata | output | DW | Target write data |
| t_ack | input | 1 | Target completion |
| t_rdata | input | DW | Target read data, valid with t_ack |

## Verification
The bench sweeps the target latency from 1 to 16 cycles and counts busy cycles, so an off-by-one in the completion path shows up as a wrong busy length. Partial-strobe writes over a known word catch a bridge that writes whole words or misorders the strobes. A byte-enable with strobes set but a zero qualifier must still behave as a read, which exposes a decode of the wrong nibble. Register writes and restarts issued mid-transfer must leave the address, data and request count untouched, which catches a bridge that lets them corrupt the access in flight.

// File: rtl/regwin_bridge.sv
module regwin_bridge #(
  parameter int DW  = 32,
  parameter int TAW = 16,
  parameter int BEW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_sel,
  input  logic           h_wr,
  input  logic [3:0]     h_addr,
  input  logic [DW-1:0]  h_wdata,
  output logic [DW-1:0]  h_rdata,
  output logic           t_req,
  output logic           t_we,
  output logic [TAW-1:0] t_addr,
  output logic [DW/8-1:0] t_strb,
  output logic [DW-1:0]  t_wdata,
  input  logic           t_ack,
  input  logic [DW-1:0]  t_rdata
);
  localparam int SW = DW / 8;

  logic           busy;
  logic           we_q;
  logic [BEW-1:0] be_q;
  logic [TAW-1:0] addr_q;
  logic [DW-1:0]  data_q;

  wire [1:0] sel   = h_addr[3:2];
  wire       hwr   = h_sel & h_wr & ~busy;
  wire       start = hwr & (sel == 2'd0) & h_wdata[0];

  logic unused_ok;
  assign unused_ok = &{1'b0, h_wdata[DW-1:TAW], h_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      we_q   <= 1'b0;
      be_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy) begin
      if (t_ack) begin
        busy <= 1'b0;
        if (!we_q) data_q <= t_rdata;
      end
    end else begin
      if (hwr && sel == 2'd1) be_q   <= h_wdata[BEW-1:0];
      if (hwr && sel == 2'd2) addr_q <= h_wdata[TAW-1:0];
      if (hwr && sel == 2'd3) data_q <= h_wdata;
      if (start) begin
        busy <= 1'b1;
        we_q <= |be_q[BEW-1:SW];
      end
    end
  end

  always_comb begin
    case (sel)
      2'd0:    h_rdata = {{(DW-1){1'b0}}, busy};
      2'd1:    h_rdata = {{(DW-BEW){1'b0}}, be_q};
      2'd2:    h_rdata = {{(DW-TAW){1'b0}}, addr_q};
      default: h_rdata = data_q;
    endcase
  end

  assign t_req   = busy;
  assign t_we    = we_q;
  assign t_addr  = addr_q;
  assign t_strb  = we_q ? be_q[SW-1:0] : '0;
  assign t_wdata = data_q;
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk #(
  parameter int DW  = 32,
  parameter int TAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           h_sel,
  input logic           h_wr,
  input logic [3:0]     h_addr,
  input logic [DW-1:0]  h_wdata,
  input logic           t_req,
  input logic           t_we,
  input logic [TAW-1:0] t_addr,
  input logic [DW/8-1:0] t_strb,
  input logic [DW-1:0]  t_wdata,
  input logic           t_ack
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_req && !t_ack |=> t_req && $stable(t_addr) && $stable(t_we) &&
                        $stable(t_strb) && $stable(t_wdata));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_req && t_ack |=> !t_req);

  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_req) |-> $past(h_sel && h_wr && h_addr[3:2] == 2'd0 && h_wdata[0]));

  // R4
  read_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_req && !t_we |-> t_strb == '0);

  // R7
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_req && !t_ack && h_sel && h_wr |=> $stable(t_addr) && $stable(t_wdata));
endmodule

bind regwin_bridge regwin_bridge_chk #(.DW(DW), .TAW(TAW)) u_chk (.*);

// File: tb/regwin_bridge_bench.sv
`timescale 1ns/1ps
module regwin_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 1'b0, h_wr = 1'b0;
  logic [3:0]  h_addr = '0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic        t_req, t_we, t_ack;
  logic [15:0] t_addr;
  logic [3:0]  t_strb;
  logic [31:0] t_wdata, t_rdata;

  int checks = 0, errors = 0;
  int lat = 1, cnt = 0, req_rises = 0;
  logic req_d = 1'b0;
  logic [31:0] mem [0:255];

  always #10 clk = ~clk;

  regwin_bridge u_regwin_bridge (.*);

  always_ff @(posedge clk) begin
    req_d <= t_req;
    if (t_req && !req_d) req_rises <= req_rises + 1;
    if (!t_req) begin
      cnt <= 0; t_ack <= 1'b0;
    end else if (t_ack) begin
      t_ack <= 1'b0;
    end else if (cnt == lat - 1) begin
      t_ack <= 1'b1;
      t_rdata <= mem[t_addr[7:0]];
      if (t_we)
        for (int b = 0; b < 4; b++)
          if (t_strb[b]) mem[t_addr[7:0]][8*b +: 8] <= t_wdata[8*b +: 8];
    end else cnt <= cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] off, input logic [31:0] v);
    h_sel = 1'b1; h_wr = 1'b1; h_addr = off; h_wdata = v;
    @(negedge clk);
    h_sel = 1'b0; h_wr = 1'b0; h_wdata = '0;
  endtask

  task automatic hr(input logic [3:0] off, output logic [31:0] v);
    h_addr = off; #1 v = h_rdata;
  endtask

  logic        s_we;
  logic [3:0]  s_strb;
  logic [31:0] s_wdata;
  logic [15:0] s_addr;

  task automatic xfer(input logic [7:0] be, input logic [15:0] a, input logic [31:0] d,
                      input int l, output int n);
    logic [31:0] v;
    lat = l;
    hw(4'h4, {24'h0, be}); hw(4'h8, {16'h0, a}); hw(4'hC, d);
    hw(4'h0, 32'h1);
    #2 s_we = t_we; s_strb = t_strb; s_wdata = t_wdata; s_addr = t_addr;
    n = 0;
    forever begin
      hr(4'h0, v);
      if (v == 0) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int o = 0; o < 16; o += 4) begin
      hr(o[3:0], v); chk(v == 0, "R1 window zero", v, 0);
    end
    chk(t_req == 0, "R1 req low", {31'b0, t_req}, 0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    int r0 = req_rises;
    hw(4'h8, 32'hFFFF_0123); hw(4'h4, 32'h0000_015A); hw(4'hC, 32'hCAFE_F00D);
    hr(4'h8, v); chk(v == 32'h0123, "R2 addr readback", v, 32'h0123);
    hr(4'h4, v); chk(v == 32'h5A, "R2 be readback", v, 32'h5A);
    hr(4'hC, v); chk(v == 32'hCAFE_F00D, "R2 data readback", v, 32'hCAFE_F00D);
    hr(4'h0, v); chk(v == 0 && t_req == 0, "R2 no start on load", v, 0);
    hw(4'h0, 32'h2); @(negedge clk);
    hr(4'h0, v); chk(v == 0, "R8 ctrl bit0 clear", v, 0);
    chk(req_rises == r0, "R8 no request", req_rises, r0);
  endtask

  task automatic t_rw(input logic [15:0] a, input logic [31:0] d, input int l);
    int n;
    logic [31:0] v;
    xfer(8'hFF, a, d, l, n);
    chk(n == l + 1, "R3 busy length write", n, l + 1);
    chk(s_we == 1 && s_strb == 4'hF, "R5 write strobes", {s_we, 27'h0, s_strb}, 32'h8000_000F);
    chk(s_wdata == d && s_addr == a, "R5 write data", s_wdata, d);
    xfer(8'h00, a, 32'h0, l, n);
    chk(n == l + 1, "R3 busy length read", n, l + 1);
    chk(s_we == 0 && s_strb == 0, "R4 read qualifiers", {s_we, 27'h0, s_strb}, 0);
    hr(4'hC, v); chk(v == d, "R4 read data", v, d);
  endtask

  task automatic t_merge();
    int n;
    logic [31:0] v;
    xfer(8'hFF, 16'h5, 32'h1122_3344, 2, n);
    xfer(8'hF1, 16'h5, 32'hAABB_CCDD, 3, n);
    xfer(8'h1A, 16'h5, 32'h5566_7788, 1, n);
    chk(s_strb == 4'hA, "R5 strobe field", s_strb, 4'hA);
    xfer(8'h0F, 16'h5, 32'h0BAD_0BAD, 2, n);
    chk(s_we == 0, "R4 zero qualifier is read", s_we, 0);
    hr(4'hC, v); chk(v == 32'h5522_77DD, "R5 merged word", v, 32'h5522_77DD);
  endtask

  task automatic t_busy_block();
    int r0;
    logic [31:0] v;
    lat = 8;
    hw(4'h4, 32'hFF); hw(4'h8, 32'h7); hw(4'hC, 32'h1234_5678);
    r0 = req_rises;
    hw(4'h0, 32'h1);
    hw(4'h8, 32'h99); hw(4'hC, 32'h0); hw(4'h4, 32'h0); hw(4'h0, 32'h1);
    hr(4'h0, v); chk(v == 1, "R7 still busy", v, 1);
    while (t_req) @(negedge clk);
    @(negedge clk);
    chk(req_rises == r0 + 1, "R7 single request", req_rises, r0 + 1);
    hr(4'h8, v); chk(v == 7, "R7 addr kept", v, 7);
    hr(4'h4, v); chk(v == 32'hFF, "R7 be kept", v, 32'hFF);
    hr(4'hC, v); chk(v == 32'h1234_5678, "R7 data kept", v, 32'h1234_5678);
    chk(mem[7] == 32'h1234_5678, "R7 target word", mem[7], 32'h1234_5678);
    hw(4'h4, 32'h0); hw(4'h0, 32'h1);
    hw(4'hC, 32'hFFFF_FFFF);
    while (t_req) @(negedge clk);
    @(negedge clk);
    hr(4'hC, v); chk(v == 32'h1234_5678, "R7 read data not overwritten", v, 32'h1234_5678);
  endtask

  initial begin
    #(20ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    t_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_rw(16'h10, 32'hDEAD_BEEF, 1);
    t_rw(16'h22, 32'h0F0F_1234, 4);
    t_rw(16'hFE, 32'h8000_0001, 16);
    t_merge();
    t_busy_block();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule